// File: doc/BRIEF.md
# Fault Confinement Error Counters

This block holds the transmit and receive error counts of a CAN-style node. It decides from them whether the node may take a full part in bus traffic, may take part only in a restricted way, or is cut off from the bus. The bit-stream processing logic sends it single-cycle strobes. Each strobe raises a counter by one or by eight, or lowers it. The block registers the resulting counts and reports two flags, one for the restricted (error-passive) state and one for the cut-off (bus-off) state.

The bus-off state is left only through a recovery pulse. That pulse is raised by the surrounding logic once the required bus-idle sequence has been seen. Counting that sequence is not part of this block. Strobes for one counter are resolved by a fixed priority. Strobes for the two counters are independent of each other, so both counters may change in the same cycle.

Top module: `fault_conf_ctr`

## Requirements
- R1: During and after reset, both counters are zero and both flags are low.
- R2: A transmit strobe adds 8 (big) or 1 (small), or subtracts 1. When more than one transmit strobe is high, big wins over small, and small wins over decrement.
- R3: A receive strobe adds 8 or 1, with the same priority as in R2. An increment past 255 leaves the receive count at 255.
- R4: A decrement of a counter that is already zero leaves it at zero. A decrement of a nonzero count below 128 subtracts one.
- R5: A receive decrement while the receive count is 128 or more sets the receive count to 127.
- R6: When not bus-off, the error-passive flag is high exactly when either count is 128 or more. The two flags are never high together.
- R7: A transmit increment whose result would exceed 255 sets the bus-off flag and leaves the transmit count at its previous value. The error-passive flag then reads low.
- R8: While bus-off, every counter strobe is ignored and both counts stay unchanged.
- R9: A recovery pulse while bus-off clears both counts and both flags in the next cycle. A recovery pulse outside bus-off has no effect.
- R10: Transmit and receive strobes in the same cycle are both applied. This includes the cycle in which bus-off is entered.
- R11: The outputs are registered. A strobe in one cycle shows on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tec_inc_small_i | input | 1 | Transmit count +1 strobe |
| tec_inc_big_i | input | 1 | Transmit count +8 strobe |
| tec_dec_i | input | 1 | Transmit count -1 strobe |
| rec_inc_small_i | input | 1 | Receive count +1 strobe |
| rec_inc_big_i | input | 1 | Receive count +8 strobe |
| rec_dec_i | input | 1 | Receive count decrement strobe |
| recover_i | input | 1 | Recovery pulse after the bus-idle sequence |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| err_passive_o | output | 1 | Error-passive state flag |
| bus_off_o | output | 1 | Bus-off state flag |

## Verification
Two functions can meet in one cycle: a receive update, and a transmit increment that overflows and enters bus-off. The bench brings the transmit count to 255. It then pulses a small transmit increment together with a big receive increment. It checks that bus-off is set, that the transmit count stays at 255, that the receive count has risen by eight, and that the error-passive flag has dropped. Mixed transmit and receive strobes in the active state, and colliding strobes on one counter, are judged the same way against the priority and independence rules.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_cnt_step.sv
module fc_cnt_step #(
    parameter int CNT_W        = 8,
    parameter int BIG_STEP     = 8,
    parameter bit HOLD_ON_OVF  = 1'b1,
    parameter bit DEC_CLAMP_EN = 1'b0,
    parameter int CLAMP_ABOVE  = 127,
    parameter int CLAMP_TO     = 127
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             inc_small_i,
    input  logic             inc_big_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] nxt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W:0]   BIG_W   = (CNT_W+1)'(BIG_STEP);
    localparam logic [CNT_W:0]   ONE_W   = (CNT_W+1)'(1);
    localparam logic [CNT_W-1:0] MAX_V   = '1;
    localparam logic [CNT_W-1:0] ABOVE_V = CNT_W'(CLAMP_ABOVE);
    localparam logic [CNT_W-1:0] TO_V    = CNT_W'(CLAMP_TO);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] inc_val;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] floor_dec;
    logic             any_inc;

    assign any_inc   = inc_small_i | inc_big_i;
    assign sum       = {1'b0, cnt_i} + (inc_big_i ? BIG_W : ONE_W);
    assign ovf_o     = any_inc & sum[CNT_W];
    assign floor_dec = (cnt_i == '0) ? cnt_i : cnt_i - 1'b1;

    generate
        if (HOLD_ON_OVF) begin : g_hold
            assign inc_val = sum[CNT_W] ? cnt_i : sum[CNT_W-1:0];
        end else begin : g_sat
            assign inc_val = sum[CNT_W] ? MAX_V : sum[CNT_W-1:0];
        end
        if (DEC_CLAMP_EN) begin : g_clamp
            assign dec_val = (cnt_i > ABOVE_V) ? TO_V : floor_dec;
        end else begin : g_plain
            assign dec_val = floor_dec;
        end
    endgenerate

    always_comb begin
        if (any_inc)    nxt_o = inc_val;
        else if (dec_i) nxt_o = dec_val;
        else            nxt_o = cnt_i;
    end
endmodule

// File: rtl/fc_state_dec.sv
module fc_state_dec
    import fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LIM = 128
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             boff_i,
    output fc_state_e        state_o
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(PASSIVE_LIM);

    always_comb begin
        if (boff_i)                              state_o = FC_BUSOFF;
        else if (tec_i >= LIM_V || rec_i >= LIM_V) state_o = FC_PASSIVE;
        else                                     state_o = FC_ACTIVE;
    end
endmodule

// File: rtl/fault_conf_ctr.sv
module fault_conf_ctr
    import fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int BIG_STEP    = 8,
    parameter int PASSIVE_LIM = 128,
    parameter int REC_CLAMP   = 127
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tec_inc_small_i,
    input  logic             tec_inc_big_i,
    input  logic             tec_dec_i,
    input  logic             rec_inc_small_i,
    input  logic             rec_inc_big_i,
    input  logic             rec_dec_i,
    input  logic             recover_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             err_passive_o,
    output logic             bus_off_o
);
    typedef struct packed {
        logic [CNT_W-1:0] tec;
        logic [CNT_W-1:0] rec;
        logic             boff;
    } fc_regs_t;

    fc_regs_t  regs_d, regs_q;
    logic [CNT_W-1:0] tec_nxt_w, rec_nxt_w;
    logic      tec_ovf_w, rec_ovf_w;
    fc_state_e state_w;

    fc_cnt_step #(
        .CNT_W(CNT_W), .BIG_STEP(BIG_STEP), .HOLD_ON_OVF(1'b1),
        .DEC_CLAMP_EN(1'b0), .CLAMP_ABOVE(REC_CLAMP), .CLAMP_TO(REC_CLAMP)
    ) tec_step_i (
        .cnt_i(regs_q.tec), .inc_small_i(tec_inc_small_i), .inc_big_i(tec_inc_big_i),
        .dec_i(tec_dec_i), .nxt_o(tec_nxt_w), .ovf_o(tec_ovf_w)
    );

    fc_cnt_step #(
        .CNT_W(CNT_W), .BIG_STEP(BIG_STEP), .HOLD_ON_OVF(1'b0),
        .DEC_CLAMP_EN(1'b1), .CLAMP_ABOVE(REC_CLAMP), .CLAMP_TO(REC_CLAMP)
    ) rec_step_i (
        .cnt_i(regs_q.rec), .inc_small_i(rec_inc_small_i), .inc_big_i(rec_inc_big_i),
        .dec_i(rec_dec_i), .nxt_o(rec_nxt_w), .ovf_o(rec_ovf_w)
    );

    fc_state_dec #(.CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM)) state_dec_i (
        .tec_i(regs_q.tec), .rec_i(regs_q.rec), .boff_i(regs_q.boff), .state_o(state_w)
    );

    always_comb begin
        regs_d = regs_q;
        if (regs_q.boff) begin
            if (recover_i) begin
                regs_d.tec  = '0;
                regs_d.rec  = '0;
                regs_d.boff = 1'b0;
            end
        end else begin
            regs_d.rec = rec_nxt_w;
            if (tec_ovf_w) regs_d.boff = 1'b1;
            else           regs_d.tec  = tec_nxt_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign tec_o         = regs_q.tec;
    assign rec_o         = regs_q.rec;
    assign err_passive_o = (state_w == FC_PASSIVE);
    assign bus_off_o     = (state_w == FC_BUSOFF);
endmodule

// File: rtl/fc_err_ctr_chk.sv
module fc_err_ctr_chk #(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LIM = 128,
    parameter int REC_CLAMP   = 127
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tec_inc_small_i,
    input logic             tec_inc_big_i,
    input logic             tec_dec_i,
    input logic             rec_inc_small_i,
    input logic             rec_inc_big_i,
    input logic             rec_dec_i,
    input logic             recover_i,
    input logic [CNT_W-1:0] tec_o,
    input logic [CNT_W-1:0] rec_o,
    input logic             err_passive_o,
    input logic             bus_off_o,
    input logic             rec_ovf_w
);
    localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] CLAMP_V = CNT_W'(REC_CLAMP);

    AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(err_passive_o && bus_off_o)); // R6

    AST_ACTIVE_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_off_o && !err_passive_o) |-> (tec_o < LIM_V && rec_o < LIM_V)); // R6

    AST_REC_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_off_o && rec_dec_i && !rec_inc_small_i && !rec_inc_big_i && rec_o > CLAMP_V)
        |=> rec_o == CLAMP_V); // R5

    AST_REC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_off_o && rec_ovf_w) |=> rec_o == '1); // R3

    AST_TEC_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_off_o && tec_o == '0 && tec_dec_i && !tec_inc_small_i && !tec_inc_big_i)
        |=> tec_o == '0); // R4

    AST_BUSOFF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_off_o) |-> tec_o == $past(tec_o)); // R7

    AST_BUSOFF_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_off_o && !recover_i) |=> (bus_off_o && $stable(tec_o) && $stable(rec_o))); // R8

    AST_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_off_o && recover_i) |=> (!bus_off_o && tec_o == '0 && rec_o == '0)); // R9
endmodule

bind fault_conf_ctr fc_err_ctr_chk #(
    .CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .REC_CLAMP(REC_CLAMP)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tec_inc_small_i(tec_inc_small_i), .tec_inc_big_i(tec_inc_big_i), .tec_dec_i(tec_dec_i),
    .rec_inc_small_i(rec_inc_small_i), .rec_inc_big_i(rec_inc_big_i), .rec_dec_i(rec_dec_i),
    .recover_i(recover_i), .tec_o(tec_o), .rec_o(rec_o),
    .err_passive_o(err_passive_o), .bus_off_o(bus_off_o), .rec_ovf_w(rec_ovf_w)
);

// File: tb/fault_conf_ctr_tb_top.sv
module fault_conf_ctr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // cmd bits: 0 tec+1, 1 tec+8, 2 tec-1, 3 rec+1, 4 rec+8, 5 rec-1, 6 recover
    localparam logic [6:0] C_T1 = 7'b0000001, C_T8 = 7'b0000010, C_TD = 7'b0000100;
    localparam logic [6:0] C_R1 = 7'b0001000, C_R8 = 7'b0010000, C_RD = 7'b0100000;
    localparam logic [6:0] C_RV = 7'b1000000;

    // {req[3:0], cmd[6:0], tec[7:0], rec[7:0], ep, bo}
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd2,  C_T8,        8'd8,  8'd0, 1'b0, 1'b0},  // R2 big step
        {4'd2,  C_T1,        8'd9,  8'd0, 1'b0, 1'b0},  // R2 small step
        {4'd2,  C_T8 | C_T1, 8'd17, 8'd0, 1'b0, 1'b0},  // R2 big beats small
        {4'd4,  C_TD,        8'd16, 8'd0, 1'b0, 1'b0},  // R4 plain decrement
        {4'd2,  C_T8 | C_TD, 8'd24, 8'd0, 1'b0, 1'b0},  // R2 increment beats decrement
        {4'd3,  C_R8,        8'd24, 8'd8, 1'b0, 1'b0},  // R3 receive big step
        {4'd10, C_R1 | C_T1, 8'd25, 8'd9, 1'b0, 1'b0},  // R10 both counters move
        {4'd10, C_RD | C_TD, 8'd24, 8'd8, 1'b0, 1'b0},  // R10 both decrement
        {4'd9,  C_RV,        8'd24, 8'd8, 1'b0, 1'b0},  // R9 recovery outside bus-off
        {4'd4,  C_RD,        8'd24, 8'd7, 1'b0, 1'b0}   // R4 receive decrement
    };

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [6:0] cmd = '0;
    logic [7:0] tec_o, rec_o;
    logic       err_passive_o, bus_off_o;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    fault_conf_ctr dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .tec_inc_small_i(cmd[0]), .tec_inc_big_i(cmd[1]), .tec_dec_i(cmd[2]),
        .rec_inc_small_i(cmd[3]), .rec_inc_big_i(cmd[4]), .rec_dec_i(cmd[5]),
        .recover_i(cmd[6]),
        .tec_o(tec_o), .rec_o(rec_o), .err_passive_o(err_passive_o), .bus_off_o(bus_off_o)
    );

    task automatic check(input string req, input logic [7:0] et, input logic [7:0] er,
                         input logic eep, input logic ebo);
        n_vec++;
        if (tec_o !== et || rec_o !== er || err_passive_o !== eep || bus_off_o !== ebo) begin
            n_bad++;
            $display("FAIL %s: got tec=%0d rec=%0d ep=%b bo=%b, want tec=%0d rec=%0d ep=%b bo=%b",
                     req, tec_o, rec_o, err_passive_o, bus_off_o, et, er, eep, ebo);
        end
    endtask

    // drive one cycle of strobes (called at a falling edge); outputs visible after the next rise
    task automatic step(input logic [6:0] c);
        cmd = c;
        @(negedge clk_i);
        cmd = '0;
    endtask

    task automatic do_reset();
        cmd    = '0;
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        check("R1", 8'd0, 8'd0, 1'b0, 1'b0);
        rst_ni = 1'b1;
    endtask

    initial begin
        @(negedge clk_i);
        do_reset();
        check("R1", 8'd0, 8'd0, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][24:18]);
            check($sformatf("R%0d (R11 vector %0d)", VEC[i][28:25], i),
                  VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R4: floor at zero for both counters
        do_reset();
        step(C_TD | C_RD);
        check("R4", 8'd0, 8'd0, 1'b0, 1'b0);

        // R6 receive threshold, R3 saturation, R5 clamp
        for (int i = 0; i < 15; i++) step(C_R8);
        check("R6", 8'd0, 8'd120, 1'b0, 1'b0);
        step(C_R8);
        check("R6", 8'd0, 8'd128, 1'b1, 1'b0);
        for (int i = 0; i < 15; i++) step(C_R8);
        check("R3", 8'd0, 8'd248, 1'b1, 1'b0);
        step(C_R8);
        check("R3", 8'd0, 8'd255, 1'b1, 1'b0);
        step(C_R1);
        check("R3", 8'd0, 8'd255, 1'b1, 1'b0);
        step(C_RD);
        check("R5", 8'd0, 8'd127, 1'b0, 1'b0);
        step(C_RD);
        check("R4", 8'd0, 8'd126, 1'b0, 1'b0);

        // R6 transmit threshold, R7 + R10 bus-off entry with receive update, R8, R9
        do_reset();
        for (int i = 0; i < 16; i++) step(C_T8);
        check("R6", 8'd128, 8'd0, 1'b1, 1'b0);
        for (int i = 0; i < 15; i++) step(C_T8);
        for (int i = 0; i < 7; i++) step(C_T1);
        check("R6", 8'd255, 8'd0, 1'b1, 1'b0);
        step(C_T1 | C_R8);
        check("R7/R10", 8'd255, 8'd8, 1'b0, 1'b1);
        step(C_TD);
        check("R8", 8'd255, 8'd8, 1'b0, 1'b1);
        step(C_RD | C_R8);
        check("R8", 8'd255, 8'd8, 1'b0, 1'b1);
        step(C_RV);
        check("R9", 8'd0, 8'd0, 1'b0, 1'b0);

        // R7: overflow from 250 keeps 250
        do_reset();
        for (int i = 0; i < 31; i++) step(C_T8);
        step(C_T1);
        step(C_T1);
        check("R2", 8'd250, 8'd0, 1'b1, 1'b0);
        step(C_T8);
        check("R7", 8'd250, 8'd0, 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule